// File: doc/BRIEF.md
# Dual-Ramp Hit Timestamp Combiner

This block forms the full arrival time of a hit on one detector channel. Two coarse bunch-crossing counters run offset from each other, and two voltage ramps alternate with a region where they overlap. When a hit arrives, the block latches both 13-bit coarse counters and an overlap-zone flag. From the low bit of the first counter it also records which ramp is the valid one.

Some time later, the conversion logic delivers the digitized level of both ramps with a strobe. The block keeps only the valid ramp's code as the fine time. It decrements the coarse count by one, wrapping modulo 8192, when the hit was in the overlap zone and the two latched counters disagree in their low bit. One clock after the strobe it presents the combined word as a single-cycle pulse.

Only one hit can be held at a time. A hit that arrives while a result is still pending is dropped and reported on an overrun pulse.

Top module: `hit_timestamp_combiner`

## Requirements
- R1: After reset, ts_valid, overrun and ts_word are all 0.
- R2: A hit sampled while nothing is pending is captured and becomes pending. The first fine_valid sampled after that raises ts_valid in the next cycle for exactly one cycle and clears the pending state.
- R3: The fine field is fine_a when bit 0 of the latched cnt_a is 0, and fine_b when that bit is 1.
- R4: With the latched overlap flag at 0, the coarse field equals the latched cnt_a.
- R5: With the overlap flag at 1 and equal bit 0 in the latched cnt_a and cnt_b, the coarse field equals the latched cnt_a.
- R6: With the overlap flag at 1 and differing bit 0 in the latched counters, the coarse field is the latched cnt_a minus one, modulo 8192, so 0 yields 8191.
- R7: A hit sampled while a result is pending does not change the latched values, and overrun is 1 for one cycle after it.
- R8: A fine_valid sampled while nothing is pending produces no ts_valid.
- R9: ts_word bits 24..12 carry the coarse field and bits 11..0 carry the fine field. Counter and overlap values are taken only on the hit cycle, so later changes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hit | input | 1 | Hit strobe from the channel discriminator |
| cnt_a | input | 13 | First coarse bunch-crossing counter |
| cnt_b | input | 13 | Second, offset coarse counter |
| in_overlap | input | 1 | High while the two ramps overlap |
| fine_valid | input | 1 | Strobe: both ramp conversion codes are ready |
| fine_a | input | 12 | Converted level of ramp A |
| fine_b | input | 12 | Converted level of ramp B |
| ts_valid | output | 1 | One-cycle pulse, ts_word holds a result |
| ts_word | output | 25 | {corrected coarse, fine} timestamp |
| overrun | output | 1 | One-cycle pulse: a hit was dropped |

## Verification
A wrongly latched counter, overlap flag or ramp choice only appears in ts_word, in the cycle after the next fine_valid. The bench therefore checks every field of each result word against its own expected value, with counters picked to sit at the wrap boundary and on both low-bit parities. A stuck pending state shows up within one cycle of a strobe, as a missing or extra ts_valid pulse or as a wrong overrun pulse after a second hit.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int COARSE_W = 13;
  localparam int FINE_W   = 12;

  typedef enum logic { RAMP_A = 1'b0, RAMP_B = 1'b1 } ramp_t;
endpackage

// File: rtl/tsc_hit_latch.sv
module tsc_hit_latch
  import tsc_pkg::*;
#(
  parameter int CW = COARSE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [CW-1:0] cnt_a,
  input  logic [CW-1:0] cnt_b,
  input  logic          in_overlap,
  input  logic          done,
  output logic          pending,
  output logic [CW-1:0] cap_a,
  output logic [CW-1:0] cap_b,
  output logic          cap_ov,
  output ramp_t         cap_ramp,
  output logic          overrun
);
  logic accept;
  logic dropped;

  assign accept  = hit && !pending;
  assign dropped = hit && pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      cap_a    <= '0;
      cap_b    <= '0;
      cap_ov   <= 1'b0;
      cap_ramp <= RAMP_A;
      overrun  <= 1'b0;
    end else begin
      overrun <= dropped;
      if (accept) begin
        pending  <= 1'b1;
        cap_a    <= cnt_a;
        cap_b    <= cnt_b;
        cap_ov   <= in_overlap;
        cap_ramp <= cnt_a[0] ? RAMP_B : RAMP_A;
      end else if (done) begin
        pending <= 1'b0;
      end
    end
  end

  // R7: an ignored hit leaves the latched state untouched
  assert_drop_keeps_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> ($stable(cap_a) && $stable(cap_b) && $stable(cap_ov)));

  // R7: the drop is reported one cycle later
  assert_overrun_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> overrun);

  // R2: an accepted hit leaves the block pending
  assert_accept_pends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> pending);
endmodule

// File: rtl/tsc_merge.sv
module tsc_merge
  import tsc_pkg::*;
#(
  parameter int CW = COARSE_W,
  parameter int FW = FINE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [CW-1:0]    cap_a,
  input  logic [CW-1:0]    cap_b,
  input  logic             cap_ov,
  input  ramp_t            cap_ramp,
  input  logic [FW-1:0]    fine_a,
  input  logic [FW-1:0]    fine_b,
  output logic             ts_valid,
  output logic [CW+FW-1:0] ts_word
);
  localparam int WW = CW + FW;

  function automatic logic [CW-1:0] fix_coarse(input logic [CW-1:0] a,
                                               input logic [CW-1:0] b,
                                               input logic ov);
    logic step_back;
    step_back = ov && (a[0] != b[0]);
    return step_back ? (a - {{(CW-1){1'b0}}, 1'b1}) : a;
  endfunction

  logic [CW-1:0] coarse_fixed;
  logic [FW-1:0] fine_pick;

  assign coarse_fixed = fix_coarse(cap_a, cap_b, cap_ov);
  assign fine_pick    = (cap_ramp == RAMP_B) ? fine_b : fine_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_valid <= 1'b0;
      ts_word  <= '0;
    end else begin
      ts_valid <= take;
      if (take) ts_word <= {coarse_fixed, fine_pick};
    end
  end

  // R4: no overlap, coarse passes through
  assert_coarse_plain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cap_ov) |=> (ts_word[WW-1:FW] == $past(cap_a)));

  // R6: wrap from zero to all ones
  assert_coarse_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cap_ov && (cap_a == '0) && cap_b[0]) |=> (ts_word[WW-1:FW] == {CW{1'b1}}));

  // R3: ramp A chosen on even counter
  assert_ramp_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cap_a[0]) |=> (ts_word[FW-1:0] == $past(fine_a)));

  // R2: result valid follows the accepted strobe; R8: nothing otherwise
  assert_valid_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ts_valid);
  assert_no_stray_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !ts_valid);
endmodule

// File: rtl/hit_timestamp_combiner.sv
module hit_timestamp_combiner
  import tsc_pkg::*;
#(
  parameter int CW = COARSE_W,
  parameter int FW = FINE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [CW-1:0]    cnt_a,
  input  logic [CW-1:0]    cnt_b,
  input  logic             in_overlap,
  input  logic             fine_valid,
  input  logic [FW-1:0]    fine_a,
  input  logic [FW-1:0]    fine_b,
  output logic             ts_valid,
  output logic [CW+FW-1:0] ts_word,
  output logic             overrun
);
  logic          pending;
  logic          take;
  logic [CW-1:0] cap_a;
  logic [CW-1:0] cap_b;
  logic          cap_ov;
  ramp_t         cap_ramp;

  assign take = fine_valid && pending;

  tsc_hit_latch #(.CW(CW)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit),
    .cnt_a      (cnt_a),
    .cnt_b      (cnt_b),
    .in_overlap (in_overlap),
    .done       (take),
    .pending    (pending),
    .cap_a      (cap_a),
    .cap_b      (cap_b),
    .cap_ov     (cap_ov),
    .cap_ramp   (cap_ramp),
    .overrun    (overrun)
  );

  tsc_merge #(.CW(CW), .FW(FW)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .cap_a    (cap_a),
    .cap_b    (cap_b),
    .cap_ov   (cap_ov),
    .cap_ramp (cap_ramp),
    .fine_a   (fine_a),
    .fine_b   (fine_b),
    .ts_valid (ts_valid),
    .ts_word  (ts_word)
  );

  // R2: a strobe completes the pending hit
  assert_strobe_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !hit) |=> !pending);
endmodule

// File: tb/sim_hit_timestamp_combiner.sv
module sim_hit_timestamp_combiner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hit = 1'b0;
  logic [12:0] cnt_a = '0;
  logic [12:0] cnt_b = '0;
  logic        in_overlap = 1'b0;
  logic        fine_valid = 1'b0;
  logic [11:0] fine_a = '0;
  logic [11:0] fine_b = '0;
  logic        ts_valid;
  logic [24:0] ts_word;
  logic        overrun;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  hit_timestamp_combiner u0 (
    .clk(clk), .rst_n(rst_n), .hit(hit), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .in_overlap(in_overlap), .fine_valid(fine_valid), .fine_a(fine_a),
    .fine_b(fine_b), .ts_valid(ts_valid), .ts_word(ts_word), .overrun(overrun)
  );

  function automatic logic [24:0] model(input logic [12:0] a, input logic [12:0] b,
                                        input logic ov, input logic [11:0] fa,
                                        input logic [11:0] fb);
    int c;
    c = int'(a);
    if (ov == 1'b1 && (a[0] ^ b[0]) == 1'b1) c = (c + 8191) % 8192;
    return {c[12:0], (a[0] ? fb : fa)};
  endfunction

  task automatic check(input string req, input logic [24:0] got, input logic [24:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one full hit/strobe transaction, checks word and pulse shape
  task automatic run_one(input string req, input logic [12:0] a, input logic [12:0] b,
                         input logic ov, input logic [11:0] fa, input logic [11:0] fb);
    hit = 1'b1; cnt_a = a; cnt_b = b; in_overlap = ov;
    @(negedge clk);
    hit = 1'b0; cnt_a = ~a; cnt_b = ~b; in_overlap = ~ov;   // R9: later changes ignored
    fine_valid = 1'b1; fine_a = fa; fine_b = fb;
    @(negedge clk);
    fine_valid = 1'b0;
    check({req, " valid"}, {24'd0, ts_valid}, 25'd1);
    check(req, ts_word, model(a, b, ov, fa, fb));
    @(negedge clk);
    check({req, " R2 pulse end"}, {24'd0, ts_valid}, 25'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    logic [12:0] ra, rb;
    void'($urandom(32'd2011));
    repeat (3) @(negedge clk);
    check("R1 valid", {24'd0, ts_valid}, 25'd0);
    check("R1 word", ts_word, 25'd0);
    check("R1 overrun", {24'd0, overrun}, 25'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_one("R4 R9 no overlap", 13'd5, 13'd4, 1'b0, 12'h111, 12'h222);
    run_one("R5 overlap same lsb", 13'd6, 13'd8, 1'b1, 12'h3a5, 12'h5a3);
    run_one("R6 wrap zero", 13'd0, 13'd1, 1'b1, 12'hfff, 12'h001);
    run_one("R6 top value", 13'd8191, 13'd0, 1'b1, 12'h010, 12'h020);
    run_one("R3 ramp B", 13'd4095, 13'd4095, 1'b0, 12'h0ab, 12'hcde);
    run_one("R3 ramp A", 13'd4096, 13'd4097, 1'b1, 12'h777, 12'h888);

    // R7: second hit while pending is dropped
    hit = 1'b1; cnt_a = 13'd100; cnt_b = 13'd101; in_overlap = 1'b1;
    @(negedge clk);
    cnt_a = 13'd33; cnt_b = 13'd40; in_overlap = 1'b0;
    @(negedge clk);
    hit = 1'b0;
    check("R7 overrun pulse", {24'd0, overrun}, 25'd1);
    @(negedge clk);
    check("R7 overrun clears", {24'd0, overrun}, 25'd0);
    fine_valid = 1'b1; fine_a = 12'h123; fine_b = 12'h456;
    @(negedge clk);
    fine_valid = 1'b0;
    check("R7 first hit kept", ts_word, model(13'd100, 13'd101, 1'b1, 12'h123, 12'h456));
    @(negedge clk);

    // R8: strobe with nothing pending
    fine_valid = 1'b1; fine_a = 12'h999;
    @(negedge clk);
    fine_valid = 1'b0;
    check("R8 no valid", {24'd0, ts_valid}, 25'd0);
    @(negedge clk);

    for (int i = 0; i < 200; i++) begin
      ra = 13'($urandom);
      rb = 13'($urandom);
      run_one((i % 2 == 0) ? "R3 R6 random" : "R4 R5 random",
              ra, rb, 1'($urandom), 12'($urandom), 12'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule